// File: doc/BRIEF.md
# Byte Transfer Counter with Maskable Status Interrupt

This block tracks a bus transfer in progress. A 24-bit byte counter is loaded with the number of bytes still to move, and a 24-bit address counter is loaded with the address of the next byte. Each pulse on the confirmed-transfer strobe means one byte has been safely delivered. On that pulse the byte counter drops by one and the address counter rises by one in the same cycle. A byte that has only been issued, and not confirmed, has no effect on either counter.

Two status bits report on the transfer. The done bit (status bit 0) marks the moment the byte counter reaches zero. The wrap bit (status bit 1) marks the address counter rolling over from all ones to zero. Software clears a status bit by writing a 1 to the same bit position of the clear port. A separate enable mask selects which status bits may drive the single interrupt request, and that request output is registered.

Top module: `byte_xfer_tracker`

## Requirements
- R1: After reset the byte count, the address, both status bits, the enable mask and the interrupt request are all zero.
- R2: A count load writes the load value into the byte count at the next edge. In a cycle with a count load, a confirmed-transfer pulse is not accepted: the count takes the loaded value and the address does not move.
- R3: A confirmed-transfer pulse with no count load and a nonzero count decreases the count by exactly one. In a cycle without such a pulse or a load, the count is unchanged.
- R4: A confirmed-transfer pulse while the count is zero is ignored. The count stays zero and the address does not change.
- R5: Each accepted transfer raises the address by one, in the same edge as the count decrement. An address load in the same cycle takes priority and writes the load value instead.
- R6: The done bit (status bit 0) is set when an accepted transfer takes the count from one to zero, and when a count of zero is loaded. A load of a nonzero count clears the done bit at that edge.
- R7: The wrap bit (status bit 1) is set when an accepted transfer takes the address from all ones to zero.
- R8: Writing the clear port clears every status bit whose clear-data bit is 1 and leaves every status bit whose clear-data bit is 0 unchanged.
- R9: When a set event and a write-one clear reach the same status bit in the same cycle, the bit ends up set.
- R10: The enable mask is loaded from the enable port on an enable write. The interrupt request is the registered OR of (status AND mask): it follows one edge after the status and mask registers, and a status bit whose mask bit is 0 never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_ack_i | input | 1 | One byte confirmed as transferred |
| cnt_ld_i | input | 1 | Load the byte count |
| cnt_ld_val_i | input | 24 | Byte count to load |
| addr_ld_i | input | 1 | Load the address counter |
| addr_ld_val_i | input | 24 | Address to load |
| clr_wr_i | input | 1 | Write strobe for the write-one-to-clear port |
| clr_bits_i | input | 2 | Clear data: bit 0 done, bit 1 wrap |
| en_wr_i | input | 1 | Write strobe for the enable mask |
| en_bits_i | input | 2 | Enable mask data: bit 0 done, bit 1 wrap |
| cnt_o | output | 24 | Current byte count |
| addr_o | output | 24 | Current address |
| status_o | output | 2 | Status: bit 0 done, bit 1 wrap |
| irq_en_o | output | 2 | Current enable mask |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Two functions can hit the same status bit in one cycle: a hardware set event, either the final byte of a count or an address rollover, and a software write-one clear of that bit. The bench provokes this by issuing the confirmed-transfer pulse in the same cycle as the clear write, once with the count at one and once with the address at all ones. It then judges the result by reading the status port after the edge and expecting the bit to be set. In the same pass it clears the other status bit, and that bit must read zero, which shows the clear really was applied in that cycle.

// File: rtl/xfer_track_pkg.sv
package xfer_track_pkg;
   localparam int ST_DONE = 0;
   localparam int ST_WRAP = 1;
   localparam int NUM_ST  = 2;
   typedef logic [NUM_ST-1:0] st_vec_t;
endpackage

// File: rtl/xfer_cnt_down.sv
module xfer_cnt_down #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld_i,
   input  logic [W-1:0] ld_val_i,
   input  logic         ack_i,
   output logic [W-1:0] cnt_o,
   output logic         step_o,
   output logic         zero_ev_o,
   output logic         ld_nz_o
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   generate
      if (W < 2) begin : g_bad_w
         $error("xfer_cnt_down: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt_q;
   logic         is_zero;

   always_comb begin
      is_zero   = (cnt_q == '0);
      step_o    = ack_i && !ld_i && !is_zero;
      zero_ev_o = (ld_i && (ld_val_i == '0)) || (step_o && (cnt_q == ONE));
      ld_nz_o   = ld_i && (ld_val_i != '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (ld_i)   cnt_q <= ld_val_i;
      else if (step_o) cnt_q <= cnt_q - ONE;
   end

   assign cnt_o = cnt_q;

   assert_load_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_i |=> cnt_q == $past(ld_val_i));
   assert_dec_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !ld_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);
   assert_zero_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_i && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/xfer_addr_up.sv
module xfer_addr_up #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld_i,
   input  logic [W-1:0] ld_val_i,
   input  logic         step_i,
   output logic [W-1:0] addr_o,
   output logic         wrap_ev_o
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   generate
      if (W < 2) begin : g_bad_w
         $error("xfer_addr_up: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] addr_q;

   assign wrap_ev_o = step_i && !ld_i && (&addr_q);

   always_ff @(posedge clk) begin
      if (!rst_n)      addr_q <= '0;
      else if (ld_i)   addr_q <= ld_val_i;
      else if (step_i) addr_q <= addr_q + ONE;
   end

   assign addr_o = addr_q;

   assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !ld_i) |=> addr_q == $past(addr_q) + ONE);
   assert_addr_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ld_i |=> addr_q == $past(ld_val_i));
   assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_ev_o |=> addr_q == '0);
endmodule

// File: rtl/xfer_stat_irq.sv
module xfer_stat_irq #(
   parameter int N       = 2,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] hwclr_i,
   input  logic         clr_wr_i,
   input  logic [N-1:0] clr_i,
   input  logic         en_wr_i,
   input  logic [N-1:0] en_i,
   output logic [N-1:0] stat_o,
   output logic [N-1:0] mask_o,
   output logic         irq_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("xfer_stat_irq: N must be at least 1");
      end
   endgenerate

   logic [N-1:0] stat_q;
   logic [N-1:0] mask_q;
   logic         irq_any;

   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_bit
         logic sw_clr;
         assign sw_clr = clr_wr_i && clr_i[g];

         always_ff @(posedge clk) begin
            if (!rst_n)                       stat_q[g] <= 1'b0;
            else if (set_i[g])                stat_q[g] <= 1'b1;
            else if (hwclr_i[g] || sw_clr)    stat_q[g] <= 1'b0;
         end

         assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> stat_q[g]);
         assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_clr && !set_i[g]) |=> !stat_q[g]);
         assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_i[g] && !hwclr_i[g] && !sw_clr) |=> stat_q[g] == $past(stat_q[g]));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (en_wr_i) mask_q <= en_i;
   end

   assign irq_any = |(stat_q & mask_q);

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_any;
         end
         assign irq_o = irq_q;

         assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_any |=> !irq_o);
         assert_irq_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
            irq_any |=> irq_o);
      end else begin : g_irq_comb
         assign irq_o = irq_any;
      end
   endgenerate

   assign stat_o = stat_q;
   assign mask_o = mask_q;
endmodule

// File: rtl/byte_xfer_tracker.sv
module byte_xfer_tracker
   import xfer_track_pkg::*;
#(
   parameter int CNT_W   = 24,
   parameter int ADDR_W  = 24,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_ack_i,
   input  logic              cnt_ld_i,
   input  logic [CNT_W-1:0]  cnt_ld_val_i,
   input  logic              addr_ld_i,
   input  logic [ADDR_W-1:0] addr_ld_val_i,
   input  logic              clr_wr_i,
   input  logic [NUM_ST-1:0] clr_bits_i,
   input  logic              en_wr_i,
   input  logic [NUM_ST-1:0] en_bits_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [NUM_ST-1:0] status_o,
   output logic [NUM_ST-1:0] irq_en_o,
   output logic              irq_o
);
   generate
      if (CNT_W < 2 || ADDR_W < 2) begin : g_bad_w
         $error("byte_xfer_tracker: counter widths must be at least 2");
      end
   endgenerate

   logic    step;
   logic    zero_ev;
   logic    ld_nz;
   logic    wrap_ev;
   st_vec_t set_vec;
   st_vec_t hwclr_vec;

   xfer_cnt_down #(.W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_i      (cnt_ld_i),
      .ld_val_i  (cnt_ld_val_i),
      .ack_i     (xfer_ack_i),
      .cnt_o     (cnt_o),
      .step_o    (step),
      .zero_ev_o (zero_ev),
      .ld_nz_o   (ld_nz)
   );

   xfer_addr_up #(.W(ADDR_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_i      (addr_ld_i),
      .ld_val_i  (addr_ld_val_i),
      .step_i    (step),
      .addr_o    (addr_o),
      .wrap_ev_o (wrap_ev)
   );

   always_comb begin
      set_vec            = '0;
      hwclr_vec          = '0;
      set_vec[ST_DONE]   = zero_ev;
      set_vec[ST_WRAP]   = wrap_ev;
      hwclr_vec[ST_DONE] = ld_nz;
   end

   xfer_stat_irq #(.N(NUM_ST), .IRQ_REG(IRQ_REG)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (set_vec),
      .hwclr_i  (hwclr_vec),
      .clr_wr_i (clr_wr_i),
      .clr_i    (clr_bits_i),
      .en_wr_i  (en_wr_i),
      .en_i     (en_bits_i),
      .stat_o   (status_o),
      .mask_o   (irq_en_o),
      .irq_o    (irq_o)
   );

   assert_done_on_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_ld_i && cnt_ld_val_i != '0) |=> !status_o[ST_DONE]);
   assert_ack_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_ack_i && !cnt_ld_i && !addr_ld_i && cnt_o == '0) |=> $stable(addr_o));
endmodule

// File: tb/byte_xfer_tracker_bench.sv
module byte_xfer_tracker_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ack = 1'b0;
   logic        ld_c = 1'b0;
   logic [23:0] ld_c_v = '0;
   logic        ld_a = 1'b0;
   logic [23:0] ld_a_v = '0;
   logic        clr_w = 1'b0;
   logic [1:0]  clr_v = '0;
   logic        en_w = 1'b0;
   logic [1:0]  en_v = '0;
   logic [23:0] cnt;
   logic [23:0] addr;
   logic [1:0]  st;
   logic [1:0]  msk;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done_flag = 1'b0;

   always #4 clk = ~clk;

   byte_xfer_tracker u_byte_xfer_tracker (
      .clk(clk), .rst_n(rst_n), .xfer_ack_i(ack),
      .cnt_ld_i(ld_c), .cnt_ld_val_i(ld_c_v),
      .addr_ld_i(ld_a), .addr_ld_val_i(ld_a_v),
      .clr_wr_i(clr_w), .clr_bits_i(clr_v),
      .en_wr_i(en_w), .en_bits_i(en_v),
      .cnt_o(cnt), .addr_o(addr), .status_o(st), .irq_en_o(msk), .irq_o(irq)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      ack = 1'b0; ld_c = 1'b0; ld_a = 1'b0; clr_w = 1'b0; en_w = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 cnt", 32'(cnt), 0);
      chk("R1 addr", 32'(addr), 0);
      chk("R1 status", 32'(st), 0);
      chk("R1 mask", 32'(msk), 0);
      chk("R1 irq", 32'(irq), 0);
   endtask

   task automatic t_load_dec();
      ld_c = 1; ld_c_v = 24'd5; ld_a = 1; ld_a_v = 24'h000100; step();
      chk("R2 load cnt", 32'(cnt), 5);
      chk("R5 load addr", 32'(addr), 32'h100);
      for (int i = 0; i < 3; i++) begin ack = 1; step(); end
      chk("R3 dec x3", 32'(cnt), 2);
      chk("R5 inc x3", 32'(addr), 32'h103);
      step();
      chk("R3 idle hold", 32'(cnt), 2);
      ack = 1; ld_c = 1; ld_c_v = 24'd9; step();
      chk("R2 load beats ack cnt", 32'(cnt), 9);
      chk("R2 load blocks addr", 32'(addr), 32'h103);
      ack = 1; ld_a = 1; ld_a_v = 24'h000800; step();
      chk("R5 addr load priority", 32'(addr), 32'h800);
      chk("R3 dec with addr load", 32'(cnt), 8);
   endtask

   task automatic t_done();
      ld_c = 1; ld_c_v = 24'd2; step();
      chk("R6 not done after load", 32'(st[0]), 0);
      ack = 1; step();
      chk("R6 not done at one", 32'(st[0]), 0);
      ack = 1; step();
      chk("R6 done at zero cnt", 32'(cnt), 0);
      chk("R6 done set", 32'(st[0]), 1);
      ld_c = 1; ld_c_v = 24'd4; step();
      chk("R6 nonzero load clears", 32'(st[0]), 0);
      ld_c = 1; ld_c_v = 24'd0; step();
      chk("R6 zero load sets", 32'(st[0]), 1);
   endtask

   task automatic t_zero_ignore();
      logic [23:0] a0;
      a0 = addr;
      ack = 1; step();
      chk("R4 cnt stays zero", 32'(cnt), 0);
      chk("R4 addr unchanged", 32'(addr), 32'(a0));
   endtask

   task automatic t_w1c();
      clr_w = 1; clr_v = 2'b10; step();
      chk("R8 zero bit no effect", 32'(st), 32'b01);
      clr_w = 1; clr_v = 2'b01; step();
      chk("R8 one bit clears", 32'(st), 0);
   endtask

   task automatic t_wrap();
      ld_c = 1; ld_c_v = 24'd3; ld_a = 1; ld_a_v = 24'hFFFFFE; step();
      ack = 1; step();
      chk("R7 no wrap yet", 32'(st[1]), 0);
      chk("R5 addr top", 32'(addr), 32'hFFFFFF);
      ack = 1; step();
      chk("R7 addr rolled", 32'(addr), 0);
      chk("R7 wrap set", 32'(st), 32'b10);
      chk("R3 cnt after wrap", 32'(cnt), 1);
   endtask

   task automatic t_collide();
      ack = 1; clr_w = 1; clr_v = 2'b11; step();
      chk("R9 done set beats clear, wrap cleared", 32'(st), 32'b01);
      ld_c = 1; ld_c_v = 24'd2; ld_a = 1; ld_a_v = 24'hFFFFFF; step();
      chk("R6 load clears done", 32'(st), 0);
      ack = 1; clr_w = 1; clr_v = 2'b10; step();
      chk("R9 wrap set beats clear", 32'(st), 32'b10);
   endtask

   task automatic t_irq();
      clr_w = 1; clr_v = 2'b11; ld_c = 1; ld_c_v = 24'd5;
      ld_a = 1; ld_a_v = 24'hFFFFFF; step();
      en_w = 1; en_v = 2'b01; step();
      chk("R10 mask written", 32'(msk), 32'b01);
      chk("R10 irq idle", 32'(irq), 0);
      ack = 1; step();
      chk("R10 wrap pending", 32'(st), 32'b10);
      step();
      chk("R10 masked bit no irq", 32'(irq), 0);
      en_w = 1; en_v = 2'b11; step();
      chk("R10 irq lags mask", 32'(irq), 0);
      step();
      chk("R10 irq raised", 32'(irq), 1);
      clr_w = 1; clr_v = 2'b10; step();
      chk("R10 irq lags clear", 32'(irq), 1);
      step();
      chk("R10 irq dropped", 32'(irq), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load_dec();
      t_done();
      t_zero_ignore();
      t_w1c();
      t_wrap();
      t_collide();
      t_irq();
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule